// File: doc/BRIEF.md
# Counted Two-Wire Bus Master Transfer Sequencer

This block sequences master transfers on a two-wire serial bus one level above the bit engine. Software programs a 10-bit target address and a byte budget, then writes a control word. That control word starts a transfer in the direction it selects. The sequencer then moves bytes between a pair of small byte buffers and the engine, one handshake at a time. In counted mode the byte budget counts down. When it reaches zero, the sequencer either issues a stop or parks the bus and signals that software may act. A repeat mode ignores the budget: it keeps draining or filling the buffers until a stop is requested.

Start and stop request bits clear themselves once they have been acted on. A negative acknowledge on the start or on any written byte cancels a pending stop and raises a sticky flag. Clearing the enable bit abandons everything at once. The remaining budget is visible at all times. Bit timing, target mode and 10-bit address framing belong to the engine or are not handled.

Top module: `bus_xfer_seq`

## Requirements
- R1: A control write stores only the bits set in mask 0xCF87 and the stored word reads back on `ctl_o`. The bit positions are: enable 15, master 10, transmit 9, 10-bit-address 8, repeat 2, stop 1, start 0.
- R2: A control write with bit 15 clear takes effect immediately. It abandons any transfer without a stop request, returns to idle, empties both buffers, zeroes the remaining count and clears all flags.
- R3: A control write with bits 15, 10 and 0 set and bit 8 clear requests a start to the stored target address. The read direction `eng_rd_o` is the inverse of bit 9. The stored bit 0 reads as 0 and both buffers are emptied. With bit 8 set, no start is issued and bit 0 stays stored.
- R4: When the start is not acknowledged, `nack_o` sets, bit 1 clears and the block returns to idle. When the start is acknowledged, the remaining count loads the programmed count.
- R5: In counted transmit, a byte is requested only while both the remaining count and the transmit level are nonzero, and each completed byte decrements the count. `xrdy_o` is set while the buffer is empty and the count is nonzero, and cleared by a buffer write.
- R6: When the count reaches zero in counted mode with bit 1 set, a stop is requested. When that stop completes, bit 1 clears, the count reloads and the block goes idle. With bit 1 clear, `ardy_o` sets, bit 10 clears and the bus stays held (`busy_o` high).
- R7: In repeat mode (bit 2), the count never changes and a stored stop bit is acted on at the next decision. Transmit sends buffered bytes and then sets `xrdy_o`. Receive reads until the receive buffer holds DEPTH bytes and resumes when a byte is removed.
- R8: A written byte that is not acknowledged sets `nack_o`, clears bit 1 and `xrdy_o`, and holds the bus with no further byte requests.
- R9: `cnt_cur_o` shows the remaining count, not the programmed value.
- R10: While idle the block makes no engine request, and transmit buffer writes are dropped.
- R11: At most one of start, stop and byte is requested at a time. A request is held until `eng_done_i`.
- R12: `nack_o` and `ardy_o` stay set until cleared by `stat_clr_i` bit 0 and bit 1 respectively.
- R13: While the bus is held, a control write with bit 1 set and no start requests a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write data |
| cnt_we_i | input | 1 | Programmed count write strobe |
| cnt_wdata_i | input | CW | Programmed byte count |
| sa_we_i | input | 1 | Target address write strobe |
| sa_wdata_i | input | AW | Target address |
| stat_clr_i | input | 2 | Flag clear pulses: bit 0 NACK, bit 1 access-ready |
| tx_wr_i | input | 1 | Push one byte into the transmit buffer |
| tx_wdata_i | input | 8 | Transmit byte |
| rx_rd_i | input | 1 | Remove the head byte of the receive buffer |
| rx_rdata_o | output | 8 | Head byte of the receive buffer |
| eng_start_o | output | 1 | Start request to the engine |
| eng_rd_o | output | 1 | Transfer direction, 1 = read |
| eng_addr_o | output | AW | Target address for the start |
| eng_stop_o | output | 1 | Stop request to the engine |
| eng_byte_o | output | 1 | Byte request to the engine |
| eng_wdata_o | output | 8 | Byte to send |
| eng_done_i | input | 1 | Engine finished the current request |
| eng_ack_i | input | 1 | Target acknowledged (start or written byte) |
| eng_rdata_i | input | 8 | Byte received by the engine |
| ctl_o | output | 16 | Stored control word |
| cnt_cur_o | output | CW | Remaining byte count |
| busy_o | output | 1 | Transfer in progress or bus held |
| nack_o | output | 1 | Sticky negative-acknowledge flag |
| ardy_o | output | 1 | Sticky access-ready flag |
| xrdy_o | output | 1 | Transmit buffer wants data |
| rrdy_o | output | 1 | Receive buffer holds data |
| tx_lvl_o | output | LW | Transmit buffer level |
| rx_lvl_o | output | LW | Receive buffer level |

## Verification
The bench logs every engine request and compares it with the sequence the requirements predict. The corner cases it targets are these. A budget that ends with and without a stop: a wrong design sends an extra byte or fails to park the bus. A NACK on the start and a NACK on a middle byte: a faulty design would still issue the pending stop or keep sending. A repeat-mode run: a design that counted down there would stall or change `cnt_cur_o`. A disable while the bus is held: a faulty design would emit a stop or leave bytes in the buffer. A full receive buffer in repeat mode must stall reads until one byte is removed, and exactly one more read must follow.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int CTL_W = 16;
  localparam logic [CTL_W-1:0] CTL_MASK = 16'hCF87;
  localparam int B_STT = 0;
  localparam int B_STP = 1;
  localparam int B_RPT = 2;
  localparam int B_XA  = 8;
  localparam int B_TRX = 9;
  localparam int B_MST = 10;
  localparam int B_EN  = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ACTIVE, ST_BYTE, ST_STOP, ST_HOLD
  } seq_st_e;

  typedef enum logic [1:0] {
    ACT_WAIT, ACT_BYTE, ACT_STOP, ACT_HALT
  } seq_act_e;
endpackage

// File: rtl/bxs_fifo.sv
module bxs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [LW-1:0] lvl_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic push_ok, pop_ok;

  assign push_ok = push_i && (lvl_q != LW'(DEPTH));
  assign pop_ok  = pop_i && (lvl_q != '0);

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wp_q <= inc(wp_q);
      if (pop_ok)  rp_q <= inc(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wp_q] <= din_i;
  end

  assign dout_o = mem_q[rp_q];
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/bxs_decide.sv
module bxs_decide
  import bxs_pkg::*;
(
  input  logic     rpt_i,
  input  logic     stp_i,
  input  logic     trx_i,
  input  logic     cnt_zero_i,
  input  logic     tx_empty_i,
  input  logic     rx_full_i,
  output seq_act_e act_o,
  output logic     xrdy_set_o
);
  always_comb begin
    act_o      = ACT_WAIT;
    xrdy_set_o = 1'b0;
    if (rpt_i) begin
      // count bypassed; stop acts at once
      if (stp_i)           act_o = ACT_STOP;
      else if (trx_i) begin
        if (!tx_empty_i)   act_o = ACT_BYTE;
        else               xrdy_set_o = 1'b1;
      end else if (!rx_full_i) act_o = ACT_BYTE;
    end else if (cnt_zero_i) begin
      act_o = stp_i ? ACT_STOP : ACT_HALT;
    end else if (trx_i) begin
      if (!tx_empty_i)     act_o = ACT_BYTE;
      else                 xrdy_set_o = 1'b1;
    end else if (!rx_full_i) begin
      act_o = ACT_BYTE;
    end
  end
endmodule

// File: rtl/bxs_fsm.sv
module bxs_fsm
  import bxs_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic [CW-1:0]    cnt_prog_i,
  input  logic [1:0]       stat_clr_i,
  input  logic             tx_push_i,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  seq_act_e         act_i,
  input  logic             xrdy_set_i,
  output seq_st_e          st_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CW-1:0]    cnt_cur_o,
  output logic             nack_o,
  output logic             ardy_o,
  output logic             xrdy_o,
  output logic             flush_o,
  output logic             tx_pop_o,
  output logic             rx_push_o
);
  seq_st_e          st_q, st_n;
  logic [CTL_W-1:0] ctl_q, ctl_n, wmask;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             nack_q, nack_n, ardy_q, ardy_n, xrdy_q, xrdy_n;
  logic             abort, start_ok, can_start;

  assign wmask     = ctl_wdata_i & CTL_MASK;
  assign abort     = ctl_we_i && !ctl_wdata_i[B_EN];
  assign can_start = (st_q == ST_IDLE) || (st_q == ST_ACTIVE) || (st_q == ST_HOLD);
  assign start_ok  = ctl_we_i && can_start && ctl_wdata_i[B_EN] && ctl_wdata_i[B_MST] &&
                     !ctl_wdata_i[B_XA] && ctl_wdata_i[B_STT];

  always_comb begin
    st_n      = st_q;
    ctl_n     = ctl_q;
    cnt_n     = cnt_q;
    nack_n    = nack_q && !stat_clr_i[0];
    ardy_n    = ardy_q && !stat_clr_i[1];
    xrdy_n    = xrdy_q;
    flush_o   = 1'b0;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    if (abort) begin
      ctl_n   = wmask;
      st_n    = ST_IDLE;
      cnt_n   = '0;
      nack_n  = 1'b0;
      ardy_n  = 1'b0;
      xrdy_n  = 1'b0;
      flush_o = 1'b1;
    end else if (start_ok) begin
      ctl_n        = wmask;
      ctl_n[B_STT] = 1'b0;
      xrdy_n       = 1'b0;
      flush_o      = 1'b1;
      st_n         = ST_START;
    end else begin
      if (ctl_we_i) ctl_n = wmask;
      unique case (st_q)
        ST_IDLE: ;
        ST_START: begin
          if (eng_done_i) begin
            if (eng_ack_i) begin
              cnt_n = cnt_prog_i;
              st_n  = ST_ACTIVE;
            end else begin
              nack_n       = 1'b1;
              ctl_n[B_STP] = 1'b0;
              st_n         = ST_IDLE;
            end
          end
        end
        ST_ACTIVE: begin
          // a control write owns the cycle
          if (!ctl_we_i) begin
            unique case (act_i)
              ACT_BYTE: st_n = ST_BYTE;
              ACT_STOP: begin
                st_n   = ST_STOP;
                xrdy_n = 1'b0;
              end
              ACT_HALT: begin
                ardy_n       = 1'b1;
                ctl_n[B_MST] = 1'b0;
                xrdy_n       = 1'b0;
                st_n         = ST_HOLD;
              end
              default: if (xrdy_set_i) xrdy_n = 1'b1;
            endcase
          end
        end
        ST_BYTE: begin
          if (eng_done_i) begin
            if (!ctl_q[B_RPT]) cnt_n = cnt_q - CW'(1);
            if (!ctl_q[B_TRX]) begin
              rx_push_o = 1'b1;
              st_n      = ST_ACTIVE;
            end else begin
              tx_pop_o = 1'b1;
              if (eng_ack_i) st_n = ST_ACTIVE;
              else begin
                nack_n       = 1'b1;
                ctl_n[B_STP] = 1'b0;
                xrdy_n       = 1'b0;
                st_n         = ST_HOLD;
              end
            end
          end
        end
        ST_STOP: begin
          if (eng_done_i) begin
            ctl_n[B_STP] = 1'b0;
            cnt_n        = cnt_prog_i;
            st_n         = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (ctl_we_i && ctl_wdata_i[B_STP]) st_n = ST_STOP;
        end
        default: st_n = ST_IDLE;
      endcase
      if (tx_push_i) xrdy_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ctl_q  <= '0;
      cnt_q  <= '0;
      nack_q <= 1'b0;
      ardy_q <= 1'b0;
      xrdy_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ctl_q  <= ctl_n;
      cnt_q  <= cnt_n;
      nack_q <= nack_n;
      ardy_q <= ardy_n;
      xrdy_q <= xrdy_n;
    end
  end

  assign st_o      = st_q;
  assign ctl_o     = ctl_q;
  assign cnt_cur_o = cnt_q;
  assign nack_o    = nack_q;
  assign ardy_o    = ardy_q;
  assign xrdy_o    = xrdy_q;
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
  import bxs_pkg::*;
#(
  parameter int CW    = 16,
  parameter int AW    = 10,
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CW-1:0]    cnt_wdata_i,
  input  logic             sa_we_i,
  input  logic [AW-1:0]    sa_wdata_i,
  input  logic [1:0]       stat_clr_i,
  input  logic             tx_wr_i,
  input  logic [7:0]       tx_wdata_i,
  input  logic             rx_rd_i,
  output logic [7:0]       rx_rdata_o,
  output logic             eng_start_o,
  output logic             eng_rd_o,
  output logic [AW-1:0]    eng_addr_o,
  output logic             eng_stop_o,
  output logic             eng_byte_o,
  output logic [7:0]       eng_wdata_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CW-1:0]    cnt_cur_o,
  output logic             busy_o,
  output logic             nack_o,
  output logic             ardy_o,
  output logic             xrdy_o,
  output logic             rrdy_o,
  output logic [LW-1:0]    tx_lvl_o,
  output logic [LW-1:0]    rx_lvl_o
);
  logic [CW-1:0] cnt_prog_q;
  logic [AW-1:0] sa_q;
  seq_st_e       st;
  seq_act_e      act;
  logic          xrdy_set, flush, tx_pop, rx_push, tx_push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_prog_q <= '0;
      sa_q       <= '0;
    end else begin
      if (cnt_we_i) cnt_prog_q <= cnt_wdata_i;
      if (sa_we_i)  sa_q       <= sa_wdata_i;
    end
  end

  assign busy_o  = (st != ST_IDLE);
  assign tx_push = tx_wr_i && busy_o;

  bxs_fifo #(.DW(8), .DEPTH(DEPTH)) u_tx_buf (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(tx_push), .din_i(tx_wdata_i),
    .pop_i(tx_pop), .dout_o(eng_wdata_o), .lvl_o(tx_lvl_o)
  );

  bxs_fifo #(.DW(8), .DEPTH(DEPTH)) u_rx_buf (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(rx_push), .din_i(eng_rdata_i),
    .pop_i(rx_rd_i), .dout_o(rx_rdata_o), .lvl_o(rx_lvl_o)
  );

  bxs_decide u_decide (
    .rpt_i(ctl_o[B_RPT]), .stp_i(ctl_o[B_STP]), .trx_i(ctl_o[B_TRX]),
    .cnt_zero_i(cnt_cur_o == '0), .tx_empty_i(tx_lvl_o == '0),
    .rx_full_i(rx_lvl_o == LW'(DEPTH)),
    .act_o(act), .xrdy_set_o(xrdy_set)
  );

  bxs_fsm #(.CW(CW)) u_fsm (
    .clk_i, .rst_ni,
    .ctl_we_i, .ctl_wdata_i, .cnt_prog_i(cnt_prog_q), .stat_clr_i,
    .tx_push_i(tx_push), .eng_done_i, .eng_ack_i,
    .act_i(act), .xrdy_set_i(xrdy_set),
    .st_o(st), .ctl_o, .cnt_cur_o, .nack_o, .ardy_o, .xrdy_o,
    .flush_o(flush), .tx_pop_o(tx_pop), .rx_push_o(rx_push)
  );

  assign eng_start_o = (st == ST_START);
  assign eng_stop_o  = (st == ST_STOP);
  assign eng_byte_o  = (st == ST_BYTE);
  assign eng_rd_o    = !ctl_o[B_TRX];
  assign eng_addr_o  = sa_q;
  assign rrdy_o      = (rx_lvl_o != '0);
endmodule

// File: rtl/bus_xfer_seq_chk.sv
module bus_xfer_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_we_i,
  input logic [15:0]   ctl_wdata_i,
  input logic          eng_start_o,
  input logic          eng_stop_o,
  input logic          eng_byte_o,
  input logic          eng_done_i,
  input logic          eng_ack_i,
  input logic          eng_rd_o,
  input logic [15:0]   ctl_o,
  input logic [CW-1:0] cnt_cur_o,
  input logic          busy_o,
  input logic          nack_o,
  input logic          ardy_o
);
  logic [2:0] reqs;
  logic       abort;
  assign reqs  = {eng_start_o, eng_stop_o, eng_byte_o};
  assign abort = ctl_we_i && !ctl_wdata_i[15];

  // R11
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reqs));

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reqs != 3'b000) && !eng_done_i && !abort |=> $stable(reqs));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (reqs == 3'b000));

  // R3
  stt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_start_o) |-> !ctl_o[0]);

  // R5
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_byte_o && eng_done_i && !ctl_o[2] && !ctl_we_i |=>
      cnt_cur_o == $past(cnt_cur_o) - CW'(1));

  // R7
  rpt_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_byte_o && eng_done_i && ctl_o[2] && !ctl_we_i |=> $stable(cnt_cur_o));

  // R8
  nack_stp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_byte_o && eng_done_i && !eng_ack_i && !eng_rd_o && !ctl_we_i |=>
      nack_o && !ctl_o[1] && !eng_byte_o && busy_o);

  // R6
  ardy_mst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ardy_o) |-> !ctl_o[10] && busy_o);
endmodule

bind bus_xfer_seq bus_xfer_seq_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
  .eng_start_o(eng_start_o), .eng_stop_o(eng_stop_o), .eng_byte_o(eng_byte_o),
  .eng_done_i(eng_done_i), .eng_ack_i(eng_ack_i), .eng_rd_o(eng_rd_o),
  .ctl_o(ctl_o), .cnt_cur_o(cnt_cur_o), .busy_o(busy_o), .nack_o(nack_o),
  .ardy_o(ardy_o)
);

// File: tb/bus_xfer_seq_tb.sv
module bus_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int AW = 10;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, cnt_we = 0, sa_we = 0, tx_wr = 0, rx_rd = 0;
  logic [15:0] ctl_wd = '0;
  logic [CW-1:0] cnt_wd = '0;
  logic [AW-1:0] sa_wd = '0;
  logic [1:0] stat_clr = '0;
  logic [7:0] tx_wd = '0;
  logic [7:0] rx_rdata, eng_wdata;
  logic eng_start, eng_rd, eng_stop, eng_byte;
  logic [AW-1:0] eng_addr;
  logic eng_done = 0, eng_ack = 0;
  logic [7:0] eng_rdata = '0;
  logic [15:0] ctl_q;
  logic [CW-1:0] cnt_cur;
  logic busy, nack, ardy, xrdy, rrdy;
  logic [LW-1:0] tx_lvl, rx_lvl;

  int checks = 0, errors = 0, overlap = 0, rd_seq = 0;
  int log_q[$];
  int exp_q[$];
  bit ack_plan[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xfer_seq #(.CW(CW), .AW(AW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .sa_we_i(sa_we), .sa_wdata_i(sa_wd),
    .stat_clr_i(stat_clr),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wd),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .eng_start_o(eng_start), .eng_rd_o(eng_rd), .eng_addr_o(eng_addr),
    .eng_stop_o(eng_stop), .eng_byte_o(eng_byte), .eng_wdata_o(eng_wdata),
    .eng_done_i(eng_done), .eng_ack_i(eng_ack), .eng_rdata_i(eng_rdata),
    .ctl_o(ctl_q), .cnt_cur_o(cnt_cur), .busy_o(busy),
    .nack_o(nack), .ardy_o(ardy), .xrdy_o(xrdy), .rrdy_o(rrdy),
    .tx_lvl_o(tx_lvl), .rx_lvl_o(rx_lvl)
  );

  // engine model: logs each request, answers one cycle later
  initial begin
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      else if (rst_n && (eng_start || eng_stop || eng_byte)) begin
        if (eng_start) begin
          log_q.push_back(1 * 4096 + {eng_rd, eng_addr});
          eng_ack = (ack_plan.size() > 0) ? ack_plan.pop_front() : 1'b1;
        end else if (eng_stop) begin
          log_q.push_back(2 * 4096);
          eng_ack = 1'b1;
        end else if (!eng_rd) begin
          log_q.push_back(3 * 4096 + eng_wdata);
          eng_ack = (ack_plan.size() > 0) ? ack_plan.pop_front() : 1'b1;
        end else begin
          eng_rdata = 8'hA0 + 8'(rd_seq);
          log_q.push_back(4 * 4096 + eng_rdata);
          rd_seq++;
          eng_ack = 1'b1;
        end
        eng_done = 1'b1;
      end
    end
  end

  // per-clock comparison of request exclusivity and idle quietness (R11, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ((32'(eng_start) + 32'(eng_stop) + 32'(eng_byte)) > 1 ||
                    (!busy && (eng_start || eng_stop || eng_byte))))
        overlap++;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic ev_chk(string r);
    chk({r, " event count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < log_q.size() && i < exp_q.size(); i++)
      chk({r, " event"}, log_q[i], exp_q[i]);
    log_q.delete();
    exp_q.delete();
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_wr(logic [15:0] v);
    ctl_wd = v; ctl_we = 1'b1; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic cnt_wr(logic [CW-1:0] v);
    cnt_wd = v; cnt_we = 1'b1; @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic sa_wr(logic [AW-1:0] v);
    sa_wd = v; sa_we = 1'b1; @(negedge clk); sa_we = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    tx_wd = b; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_chk(string r, logic [7:0] exp);
    chk(r, rx_rdata, exp);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic clr(logic [1:0] m);
    stat_clr = m; @(negedge clk); stat_clr = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int base;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // reset state
    chk("R1 reset ctl", ctl_q, 0);
    chk("R9 reset count", cnt_cur, 0);
    chk("R10 reset busy", busy, 0);
    chk("R12 reset flags", {nack, ardy, xrdy, rrdy}, 0);

    // mask and 10-bit-address refusal
    ctl_wr(16'hFFFF);
    cyc(3);
    chk("R1 mask", ctl_q, 16'hCF87);
    chk("R3 no start with bit 8", busy, 0);
    ev_chk("R3 no start with bit 8");
    ctl_wr(16'h0000);
    chk("R1 cleared", ctl_q, 0);

    // idle writes dropped
    push(8'h77);
    cyc(2);
    chk("R10 idle tx drop", tx_lvl, 0);
    ev_chk("R10 idle quiet");

    // counted transmit with stop
    sa_wr(10'h2A5);
    cnt_wr(3);
    ctl_wr(16'h8603);
    cyc(3);
    chk("R4 count load", cnt_cur, 3);
    chk("R5 xrdy on empty", xrdy, 1);
    push(8'h11);
    chk("R5 xrdy cleared by write", xrdy, 0);
    push(8'h22);
    push(8'h33);
    wait_idle();
    exp_q = '{1*4096 + 12'h2A5, 3*4096 + 8'h11, 3*4096 + 8'h22, 3*4096 + 8'h33, 2*4096};
    ev_chk("R5 R6 counted transmit");
    chk("R6 stop bit cleared", ctl_q, 16'h8600);
    chk("R6 count reload", cnt_cur, 3);
    chk("R6 xrdy after stop", xrdy, 0);
    chk("R6 no ardy with stop", ardy, 0);

    // counted receive, no stop: bus held
    cnt_wr(2);
    base = rd_seq;
    ctl_wr(16'h8401);
    cyc(20);
    exp_q = '{1*4096 + 12'h6A5, 4*4096 + 8'hA0 + base, 4*4096 + 8'hA1 + base};
    ev_chk("R6 counted receive");
    chk("R6 ardy set", ardy, 1);
    chk("R6 master cleared", ctl_q, 16'h8000);
    chk("R6 bus held", busy, 1);
    chk("R9 remaining zero", cnt_cur, 0);
    chk("R6 rx level", rx_lvl, 2);
    chk("R6 rrdy", rrdy, 1);
    pop_chk("R6 rx byte 0", 8'(8'hA0 + base));
    pop_chk("R6 rx byte 1", 8'(8'hA1 + base));
    chk("R6 rx drained", rx_lvl, 0);
    ctl_wr(16'h8002);
    wait_idle();
    exp_q = '{2*4096};
    ev_chk("R13 stop from hold");
    chk("R13 idle after stop", busy, 0);
    chk("R13 count reload", cnt_cur, 2);
    chk("R12 ardy sticky", ardy, 1);
    clr(2'b10);
    chk("R12 ardy cleared", ardy, 0);

    // start NACK
    ack_plan = '{1'b0};
    ctl_wr(16'h8603);
    cyc(10);
    exp_q = '{1*4096 + 12'h2A5};
    ev_chk("R4 start nack");
    chk("R4 nack flag", nack, 1);
    chk("R4 stop cleared", ctl_q, 16'h8600);
    chk("R4 idle after nack", busy, 0);
    cyc(5);
    chk("R12 nack sticky", nack, 1);
    clr(2'b01);
    chk("R12 nack cleared", nack, 0);

    // data NACK mid transfer, then disable
    cnt_wr(4);
    ack_plan = '{1'b1, 1'b1, 1'b1, 1'b0};
    ctl_wr(16'h8603);
    cyc(3);
    push(8'h51);
    push(8'h52);
    push(8'h53);
    push(8'h54);
    cyc(20);
    exp_q = '{1*4096 + 12'h2A5, 3*4096 + 8'h51, 3*4096 + 8'h52, 3*4096 + 8'h53};
    ev_chk("R8 data nack");
    chk("R8 nack flag", nack, 1);
    chk("R8 stop cleared", ctl_q, 16'h8600);
    chk("R8 bus held", busy, 1);
    chk("R8 xrdy cleared", xrdy, 0);
    chk("R9 remaining after nack", cnt_cur, 1);
    chk("R8 byte left", tx_lvl, 1);
    ctl_wr(16'h0000);
    cyc(5);
    ev_chk("R2 no stop on disable");
    chk("R2 idle", busy, 0);
    chk("R2 tx flushed", tx_lvl, 0);
    chk("R2 count zero", cnt_cur, 0);
    chk("R2 flags cleared", {nack, ardy}, 0);

    // repeat-mode transmit
    cnt_wr(1);
    ctl_wr(16'h8605);
    cyc(3);
    push(8'h61);
    push(8'h62);
    push(8'h63);
    cyc(15);
    exp_q = '{1*4096 + 12'h2A5, 3*4096 + 8'h61, 3*4096 + 8'h62, 3*4096 + 8'h63};
    ev_chk("R7 repeat transmit");
    chk("R7 count unchanged", cnt_cur, 1);
    chk("R7 xrdy after drain", xrdy, 1);
    chk("R7 still busy", busy, 1);
    ctl_wr(16'h8606);
    wait_idle();
    exp_q = '{2*4096};
    ev_chk("R7 immediate stop");
    chk("R7 stop cleared", ctl_q, 16'h8604);

    // repeat-mode receive fills the buffer then stalls
    base = rd_seq;
    ctl_wr(16'h8405);
    cyc(25);
    exp_q = '{1*4096 + 12'h6A5};
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(4*4096 + 8'(8'hA0 + base + i));
    ev_chk("R7 repeat receive fill");
    chk("R7 rx full", rx_lvl, DEPTH);
    pop_chk("R7 rx head", 8'(8'hA0 + base));
    cyc(10);
    exp_q = '{4*4096 + 8'(8'hA0 + base + DEPTH)};
    ev_chk("R7 one more read");
    ctl_wr(16'h8406);
    wait_idle();
    exp_q = '{2*4096};
    ev_chk("R7 receive stop");

    chk("R11 request overlap", overlap, 0);
    summary();
  end
endmodule